// File: doc/BRIEF.md
# Almost-Full Hysteresis Flag Generator

This block watches how many locations of a receive FIFO are still empty and produces an active-low almost-full flag with hysteresis. Two programmable 9-bit thresholds are used. The lower threshold sets when the flag is raised. The upper threshold sets when it is released. Both are counts of empty locations, not filled ones. While the flag is raised, the block also raises a stop request. This tells the status-channel serializer to send flow-control "stop" information in place of ordinary FIFO fill levels. When the flag drops, the stop request drops and normal level reporting resumes.

Threshold values come from a configuration source through a write strobe. They are accepted only while the block is disabled. Each value is clamped to its legal range. The release threshold is never allowed below the effective raise threshold. On the clock edge where the enable is first seen high, the clamped pair is frozen into the working registers, so the comparators always see a stable pair while the block runs. The empty count is a level that is sampled on every clock. It has no handshake, and the block never stalls its producer. Control and status pins are plain wires.

Top module: `af_hyst_flag_gen`

## Requirements
- R1: While reset is active, and on the first sample after reset, `af_n_o` is 1 and `stop_req_o` is 0.
- R2: The effective raise threshold is the programmed `cfg_on_thr_i` limited to the range 1..508. A value of 0 acts as 1, and values 509..511 act as 508.
- R3: The effective release threshold is the programmed `cfg_off_thr_i` limited to the range from the effective raise threshold up to 508. A smaller value acts as the raise threshold, and a larger value acts as 508.
- R4: While enabled, an empty count at or below the effective raise threshold drives `af_n_o` to 0 and `stop_req_o` to 1. If the count equals both thresholds, raising wins.
- R5: While enabled, an empty count at or above the effective release threshold, and also above the raise threshold, drives `af_n_o` back to 1 and `stop_req_o` to 0. A count strictly between the two thresholds leaves both outputs unchanged.
- R6: `cfg_wr_i` updates the stored thresholds only in a cycle where `enable_i` is 0. The stored pair becomes effective on the edge where `enable_i` is first sampled high. A write made while enabled is discarded: it affects neither the running pair nor any later enable.
- R7: At every edge where `enable_i` is sampled 0, and at the edge where it is first sampled high, the flag state is cleared (`af_n_o` = 1).
- R8: The outputs reflect the empty count sampled at the immediately preceding rising edge. A change of the count between edges does not alter the outputs until that edge.
- R9: At every sample point, `stop_req_o` is the inverse of `af_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Run enable; thresholds load on its first high sample |
| cfg_wr_i | input | 1 | Threshold write strobe, honoured only while disabled |
| cfg_on_thr_i | input | 9 | Raise threshold, in empty locations |
| cfg_off_thr_i | input | 9 | Release threshold, in empty locations |
| empty_cnt_i | input | CNT_W (10) | Current number of empty FIFO locations |
| af_n_o | output | 1 | Almost-full flag, active low |
| stop_req_o | output | 1 | Request to send flow-control stop status instead of levels |

## Verification
The bench uses the default parameters: a 10-bit empty count and clamp limits of 1 and 508. This means every 9-bit register value, including 0 and 509..511, can drive both clamps. Counts above 508 can also be presented to test release at the upper bound. A table of counts walks the flag through raise, hold, release and re-raise against the pair 10/20. Directed cases then cover clamping at both ends, inverted pairs, equal thresholds, writes made while enabled, enable drop, and the single-edge latency.

// File: rtl/af_pkg.sv
package af_pkg;

  localparam int THR_W = 9;

  typedef logic [THR_W-1:0] thr_t;

  // Threshold pair in empty-location units: lo_mark raises, hi_mark releases.
  typedef struct packed {
    thr_t lo_mark;
    thr_t hi_mark;
  } af_thr_s;

  typedef enum logic {
    AF_CLEAR = 1'b0,
    AF_SET   = 1'b1
  } af_state_e;

endpackage

// File: rtl/af_thr_clamp.sv
module af_thr_clamp
  import af_pkg::*;
#(
  parameter int THR_MIN = 1,
  parameter int THR_MAX = 508
) (
  input  af_thr_s raw_i,
  output af_thr_s eff_o
);

  localparam thr_t LIM_LO = thr_t'(THR_MIN);
  localparam thr_t LIM_HI = thr_t'(THR_MAX);

  thr_t on_eff;
  thr_t off_eff;

  // Raise threshold: bounded on both sides.
  always_comb begin
    if (raw_i.lo_mark < LIM_LO)      on_eff = LIM_LO;
    else if (raw_i.lo_mark > LIM_HI) on_eff = LIM_HI;
    else                             on_eff = raw_i.lo_mark;
  end

  // Release threshold: never below the effective raise threshold.
  always_comb begin
    if (raw_i.hi_mark < on_eff)      off_eff = on_eff;
    else if (raw_i.hi_mark > LIM_HI) off_eff = LIM_HI;
    else                             off_eff = raw_i.hi_mark;
  end

  assign eff_o.lo_mark = on_eff;
  assign eff_o.hi_mark = off_eff;

endmodule

// File: rtl/af_thr_bank.sv
module af_thr_bank
  import af_pkg::*;
#(
  parameter int THR_MIN = 1,
  parameter int THR_MAX = 508,
  parameter int RST_ON  = 16,
  parameter int RST_OFF = 32
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable_i,
  input  logic    cfg_wr_i,
  input  af_thr_s cfg_i,
  output af_thr_s act_o,
  output logic    armed_o
);

  af_thr_s shadow_q;
  af_thr_s shadow_eff;
  af_thr_s act_q;
  logic    armed_q;

  // Static registers: writes land only while disabled.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q.lo_mark <= thr_t'(RST_ON);
      shadow_q.hi_mark <= thr_t'(RST_OFF);
    end else if (cfg_wr_i && !enable_i) begin
      shadow_q <= cfg_i;
    end
  end

  af_thr_clamp #(
    .THR_MIN (THR_MIN),
    .THR_MAX (THR_MAX)
  ) u_clamp (
    .raw_i (shadow_q),
    .eff_o (shadow_eff)
  );

  // Freeze the clamped pair on the first enabled sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      act_q   <= '0;
    end else begin
      armed_q <= enable_i;
      if (enable_i && !armed_q) act_q <= shadow_eff;
    end
  end

  assign act_o   = act_q;
  assign armed_o = armed_q;

  p_on_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (act_q.lo_mark >= thr_t'(THR_MIN)) && (act_q.lo_mark <= thr_t'(THR_MAX)));

  p_off_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (act_q.hi_mark >= act_q.lo_mark) && (act_q.hi_mark <= thr_t'(THR_MAX)));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && enable_i) |=> $stable(act_q));

  p_shadow_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |=> $stable(shadow_q));

  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !armed_q) |=> armed_q);

endmodule

// File: rtl/af_hyst_core.sv
module af_hyst_core
  import af_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             armed_i,
  input  af_thr_s          thr_i,
  input  logic [CNT_W-1:0] empty_cnt_i,
  output logic             af_o
);

  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] on_x;
  logic [CMP_W-1:0] off_x;
  logic             hit_on;
  logic             hit_off;
  af_state_e        st_q;

  assign cnt_x   = CMP_W'(empty_cnt_i);
  assign on_x    = CMP_W'(thr_i.lo_mark);
  assign off_x   = CMP_W'(thr_i.hi_mark);
  assign hit_on  = (cnt_x <= on_x);
  assign hit_off = (cnt_x >= off_x);

  // Raise takes priority; between the marks the state is held.
  always_ff @(posedge clk) begin
    if (!rst_n)                    st_q <= AF_CLEAR;
    else if (!enable_i || !armed_i) st_q <= AF_CLEAR;
    else if (hit_on)               st_q <= AF_SET;
    else if (hit_off)              st_q <= AF_CLEAR;
  end

  assign af_o = (st_q == AF_SET);

  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && armed_i && (cnt_x <= on_x)) |=> af_o);

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && armed_i && (cnt_x > on_x) && (cnt_x >= off_x)) |=> !af_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && armed_i && (cnt_x > on_x) && (cnt_x < off_x)) |=> $stable(af_o));

  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !af_o);

endmodule

// File: rtl/af_hyst_flag_gen.sv
module af_hyst_flag_gen
  import af_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int THR_MIN = 1,
  parameter int THR_MAX = 508,
  parameter int RST_ON  = 16,
  parameter int RST_OFF = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             cfg_wr_i,
  input  logic [8:0]       cfg_on_thr_i,
  input  logic [8:0]       cfg_off_thr_i,
  input  logic [CNT_W-1:0] empty_cnt_i,
  output logic             af_n_o,
  output logic             stop_req_o
);

  af_thr_s cfg_pair;
  af_thr_s act_pair;
  logic    armed;
  logic    af;

  assign cfg_pair.lo_mark = thr_t'(cfg_on_thr_i);
  assign cfg_pair.hi_mark = thr_t'(cfg_off_thr_i);

  af_thr_bank #(
    .THR_MIN (THR_MIN),
    .THR_MAX (THR_MAX),
    .RST_ON  (RST_ON),
    .RST_OFF (RST_OFF)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .cfg_wr_i (cfg_wr_i),
    .cfg_i    (cfg_pair),
    .act_o    (act_pair),
    .armed_o  (armed)
  );

  af_hyst_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .armed_i     (armed),
    .thr_i       (act_pair),
    .empty_cnt_i (empty_cnt_i),
    .af_o        (af)
  );

  assign af_n_o     = ~af;
  assign stop_req_o = af;

  p_stop_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_o != af_n_o);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> af_n_o);

endmodule

// File: tb/tb_af_hyst_flag_gen.sv
module tb_af_hyst_flag_gen;

  localparam int CNT_W = 10;
  localparam int NVEC  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable_i = 1'b0;
  logic             cfg_wr_i = 1'b0;
  logic [8:0]       cfg_on_thr_i = '0;
  logic [8:0]       cfg_off_thr_i = '0;
  logic [CNT_W-1:0] empty_cnt_i = '0;
  logic             af_n_o;
  logic             stop_req_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  af_hyst_flag_gen #(.CNT_W(CNT_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_on_thr_i  (cfg_on_thr_i),
    .cfg_off_thr_i (cfg_off_thr_i),
    .empty_cnt_i   (empty_cnt_i),
    .af_n_o        (af_n_o),
    .stop_req_o    (stop_req_o)
  );

  // {empty count, expected af_n} for thresholds 10 (raise) / 20 (release)
  localparam logic [10:0] VEC [NVEC] = '{
    {10'd100, 1'b1}, {10'd20, 1'b1}, {10'd11, 1'b1}, {10'd10, 1'b0},
    {10'd5,   1'b0}, {10'd15, 1'b0}, {10'd19, 1'b0}, {10'd20, 1'b1},
    {10'd15,  1'b1}, {10'd11, 1'b1}, {10'd0,  1'b0}, {10'd12, 1'b0},
    {10'd21,  1'b1}, {10'd1023, 1'b1}, {10'd9, 1'b0}, {10'd511, 1'b1}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_out(string tag, logic exp_n);
    chk(tag, af_n_o, exp_n);
    chk("R9", stop_req_o, ~exp_n);
  endtask

  task automatic program_thr(int on_v, int off_v);
    enable_i      = 1'b0;
    cfg_wr_i      = 1'b1;
    cfg_on_thr_i  = 9'(on_v);
    cfg_off_thr_i = 9'(off_v);
    step();
    cfg_wr_i = 1'b0;
  endtask

  task automatic arm();
    enable_i = 1'b1;
    step();
  endtask

  task automatic apply(int cnt, string tag, logic exp_n);
    empty_cnt_i = CNT_W'(cnt);
    step();
    chk_out(tag, exp_n);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    chk_out("R1", 1'b1);
    rst_n = 1'b1;
    step();
    chk_out("R1", 1'b1);

    // Main table walk
    program_thr(10, 20);
    empty_cnt_i = CNT_W'(3);
    arm();
    chk_out("R7", 1'b1);  // load edge clears state even with low count
    for (int i = 0; i < NVEC; i++) begin
      apply(int'(VEC[i][10:1]), "R4/R5", VEC[i][0]);
    end

    // R8: count change between edges not visible until the edge
    apply(100, "R8", 1'b1);
    empty_cnt_i = CNT_W'(2);
    #1;
    chk_out("R8", 1'b1);
    step();
    chk_out("R8", 1'b0);

    // R6: write while enabled ignored now and after re-enable
    cfg_wr_i = 1'b1; cfg_on_thr_i = 9'd100; cfg_off_thr_i = 9'd200;
    empty_cnt_i = CNT_W'(50);
    step();
    cfg_wr_i = 1'b0;
    chk_out("R6", 1'b1);
    enable_i = 1'b0;
    step();
    chk_out("R7", 1'b1);
    arm();
    apply(50, "R6", 1'b1);
    apply(10, "R6", 1'b0);

    // R7: dropping enable clears a raised flag
    enable_i = 1'b0;
    step();
    chk_out("R7", 1'b1);

    // R2/R3: zero values clamp to 1/1
    program_thr(0, 0);
    arm();
    apply(2, "R2", 1'b1);
    apply(1, "R2", 1'b0);
    apply(2, "R3", 1'b1);

    // R2/R3: top values clamp to 508/508
    program_thr(511, 511);
    arm();
    apply(509, "R2", 1'b1);
    apply(508, "R2", 1'b0);
    apply(509, "R3", 1'b1);

    // R3: release below raise acts as raise
    program_thr(50, 30);
    arm();
    apply(50, "R3", 1'b0);
    apply(51, "R3", 1'b1);

    // R3: release above 508 acts as 508
    program_thr(100, 510);
    arm();
    apply(90, "R3", 1'b0);
    apply(508, "R3", 1'b1);

    // R4: equal thresholds, raise wins at the shared point
    program_thr(40, 40);
    arm();
    apply(40, "R4", 1'b0);
    apply(41, "R5", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule